// File: doc/BRIEF.md
# TDM Time-Slot Switch with Message Mode

This block moves bytes between serial time-division streams. A frame pulse marks the start of each frame, and one system clock, running at the fastest bit rate, times every stream. Each input stream is shifted in bit by bit, and each completed 8-bit channel is stored in a data memory. For every output channel, a connection entry chooses one of two sources: any stored input channel, from any stream and at any rate, or a fixed byte written by the host. In the second case that byte is sent again in every frame.

The data memory has two halves, selected by frame parity. While the current frame fills one half, the outputs read the other half. The delay through the switch is therefore always exactly one frame. Each stream has its own input rate, output rate and bidirectional setting. Each output stream has a driver-enable output, and the lower half of the streams also have an active-high high-impedance control.

The frame is scaled down to 256 clocks. The rate code selects 4, 8, 16 or 32 channels per frame. After reset, every connection entry is disabled and points at the input stream and channel with its own number.

Top module: `tdm_tsi`

## Requirements
- R1: While rst_n is low, st_en is all zero, st_out is all zero and hz_ctl is all ones. If the host writes nothing after release, every output channel stays disabled for whole frames.
- R2: A cycle with fp_i high is frame position 0, whatever the position counter held before. A frame lasts 256 clocks. A byte received in an input channel during one frame is sent on each output channel mapped to it during the next frame, MSB first. The output bit for frame position p is visible in the clock after p.
- R3: Each stream has a 2-bit rate code k, for input and output separately. Code k gives a bit period of 8>>k clocks and 4<<k channels per frame. An input bit is sampled at clock offset (period/2) within its bit, where offset 0 is used when the period is one clock. Input and output rates may differ.
- R4: A connection entry with bit 9 set sends its bits 7:0 on that output channel in every frame, for as long as the entry is unchanged.
- R5: A connection entry with bit 8 clear holds st_en and st_out low for every bit of that channel. With bit 8 set, st_en is high.
- R6: A stream whose bidirectional bit is set writes nothing to the data memory. Outputs switched from that stream keep sending what the memory held before.
- R7: For each stream i below NSTR/2, hz_ctl[i] is the inverse of st_en[i] in every cycle.
- R8: Host writes use wr_addr[7] to choose the target. When wr_addr[7] is 0, the write goes to connection entry {output stream wr_addr[6:5], output channel wr_addr[4:0]}. The data is {message bit 9, enable bit 8, payload 7:0}, and for switching the payload holds the source stream in bits 6:5 and the source channel in bits 4:0. When wr_addr[7] is 1, the write goes to the configuration of stream wr_addr[1:0]: data[1:0] is the input rate, data[3:2] the output rate and data[4] the bidirectional bit. A write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at the fastest bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse; high in the cycle at frame position 0 |
| st_in | input | NSTR (4) | Serial input streams |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1+log2(NSTR)+log2(8*CHB) (8) | Host write address |
| wr_data | input | PW+2 (10) | Host write data |
| st_out | output | NSTR (4) | Serial output streams |
| st_en | output | NSTR (4) | Per-stream driver enable for the current bit |
| hz_ctl | output | NSTR/2 (2) | High-impedance control for the lower streams, high when not driving |

## Verification
The bench changes the input bytes in every frame. A switch with zero or two frames of delay, or one that reads the half being written, therefore sends wrong bytes at once. Rates are crossed in both directions, from the slowest input to the fastest output and back. This exposes a sampling tick at the wrong offset or a channel index that is not scaled. Message and disabled entries are mixed with switched entries in the same frame, so a wrong select or a leaked enable shows up as a wrong byte. A bidirectional stream is given new input data, and that data must never reach the outputs that read it. A design that kept writing would replay the new bytes instead of the held ones.

// File: rtl/tdm_tsi.sv
module tdm_tsi #(
  parameter int NSTR = 4,
  parameter int CHB = 4,
  localparam int CHMAX = CHB * 8,
  localparam int CW = $clog2(CHMAX),
  localparam int SW = $clog2(NSTR),
  localparam int FRAME = CHMAX * 8,
  localparam int PCW = $clog2(FRAME),
  localparam int PW = (SW + CW > 8) ? (SW + CW) : 8,
  localparam int EW = PW + 2,
  localparam int AW = 1 + SW + CW,
  localparam int NHZ = NSTR / 2,
  localparam int DEPTH = 2 * CHMAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_i,
  input  logic [NSTR-1:0] st_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [EW-1:0]   wr_data,
  output logic [NSTR-1:0] st_out,
  output logic [NSTR-1:0] st_en,
  output logic [NHZ-1:0]  hz_ctl
);

  function automatic logic [PCW-1:0] bit_index(input logic [PCW-1:0] p, input logic [1:0] r);
    return p >> (2'd3 - r);
  endfunction

  function automatic logic mid_bit(input logic [PCW-1:0] p, input logic [1:0] r);
    logic [PCW-1:0] per;
    per = PCW'(1) << (2'd3 - r);
    return (p & (per - PCW'(1))) == (per >> 1);
  endfunction

  logic [PCW-1:0] cnt_q, pos;
  logic           par_q, par_now;

  assign pos     = fp_i ? '0 : cnt_q;
  assign par_now = (pos == '0) ? ~par_q : par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else begin
      cnt_q <= pos + PCW'(1);
      par_q <= par_now;
    end
  end

  logic [NSTR-1:0][4:0] ctl_q;
  logic [EW-1:0]        cmem [NSTR*CHMAX];
  logic                 is_ctl;

  assign is_ctl = wr_addr[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      for (int i = 0; i < NSTR * CHMAX; i++) cmem[i] <= EW'(i);
    end else if (wr_en) begin
      if (is_ctl) ctl_q[wr_addr[SW-1:0]] <= wr_data[4:0];
      else        cmem[wr_addr[SW+CW-1:0]] <= wr_data;
    end
  end

  logic [6:0]     shr  [NSTR];
  logic [7:0]     dmem [NSTR][DEPTH];
  logic [PCW-1:0] ibit [NSTR];
  logic [NSTR-1:0] tick, done;

  always_comb begin
    for (int s = 0; s < NSTR; s++) begin
      ibit[s] = bit_index(pos, ctl_q[s][1:0]);
      tick[s] = mid_bit(pos, ctl_q[s][1:0]);
      done[s] = tick[s] && (ibit[s][2:0] == 3'd7) && !ctl_q[s][4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTR; s++) begin
        shr[s] <= '0;
        for (int a = 0; a < DEPTH; a++) dmem[s][a] <= '0;
      end
    end else begin
      for (int s = 0; s < NSTR; s++) begin
        if (tick[s]) shr[s] <= {shr[s][5:0], st_in[s]};
        if (done[s]) dmem[s][{par_now, ibit[s][CW+2:3]}] <= {shr[s], st_in[s]};
      end
    end
  end

  logic [PCW-1:0] ob   [NSTR];
  logic [EW-1:0]  ent  [NSTR];
  logic [7:0]     byt  [NSTR];
  logic [NSTR-1:0] nxt_bit, nxt_en;

  always_comb begin
    for (int o = 0; o < NSTR; o++) begin
      ob[o]  = bit_index(pos, ctl_q[o][3:2]);
      ent[o] = cmem[{SW'(o), ob[o][CW+2:3]}];
      if (ent[o][EW-1]) byt[o] = ent[o][7:0];
      else              byt[o] = dmem[ent[o][SW+CW-1:CW]][{~par_now, ent[o][CW-1:0]}];
      nxt_en[o]  = ent[o][EW-2];
      nxt_bit[o] = ent[o][EW-2] & byt[o][3'd7 - ob[o][2:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_out <= '0;
      st_en  <= '0;
      hz_ctl <= '1;
    end else begin
      st_out <= nxt_bit;
      st_en  <= nxt_en;
      hz_ctl <= ~nxt_en[NHZ-1:0];
    end
  end

endmodule

module tdm_tsi_chk #(
  parameter int NSTR = 4,
  parameter int CHB = 4,
  localparam int CHMAX = CHB * 8,
  localparam int SW = $clog2(NSTR),
  localparam int PCW = $clog2(CHMAX * 8),
  localparam int NHZ = NSTR / 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fp_i,
  input logic                 wr_en,
  input logic                 ctl_sel,
  input logic [SW-1:0]        ctl_idx,
  input logic [4:0]           ctl_wd,
  input logic [PCW-1:0]       cnt_q,
  input logic [NSTR-1:0][4:0] ctl_q,
  input logic [NSTR-1:0]      st_out,
  input logic [NSTR-1:0]      st_en,
  input logic [NHZ-1:0]       hz_ctl
);

  AST_RESET_SAFE: assert property (@(posedge clk) !rst_n |-> (st_en == '0 && st_out == '0 && hz_ctl == '1)); // R1
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n) fp_i |=> cnt_q == PCW'(1)); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (st_out & ~st_en) == '0); // R5
  AST_HZ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) hz_ctl == ~st_en[NHZ-1:0]); // R7
  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctl_sel) |=> ctl_q[$past(ctl_idx)] == $past(ctl_wd)); // R8

endmodule

bind tdm_tsi tdm_tsi_chk #(.NSTR(NSTR), .CHB(CHB)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .wr_en(wr_en),
  .ctl_sel(wr_addr[AW-1]), .ctl_idx(wr_addr[SW-1:0]), .ctl_wd(wr_data[4:0]),
  .cnt_q(cnt_q), .ctl_q(ctl_q), .st_out(st_out), .st_en(st_en), .hz_ctl(hz_ctl)
);

// File: tb/test_tdm_tsi.sv
`timescale 1ns/1ps
module test_tdm_tsi;
  localparam int NS = 4, CHB = 4, CHMAX = 32, NHZ = 2;

  logic clk = 1'b0, rst_n = 1'b1, fp_i = 1'b0, wr_en = 1'b0;
  logic [NS-1:0] st_in = '0;
  logic [7:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [NS-1:0] st_out, st_en;
  logic [NHZ-1:0] hz_ctl;

  int n_chk = 0, n_fail = 0, fr = 0;

  logic [7:0] inb [NS][CHMAX];
  logic [7:0] dm [2][NS][CHMAX];
  logic [9:0] cm [NS][CHMAX];
  logic [9:0] cm_n [NS][CHMAX];
  logic [1:0] irt [NS], ort [NS], irt_n [NS], ort_n [NS];
  logic bd [NS], bd_n [NS];
  logic [7:0] q_a [256];
  logic [9:0] q_d [256];
  int nq = 0;
  logic [7:0] pex [NS][CHMAX];
  logic pexen [NS][CHMAX], pmsg [NS][CHMAX];
  int pnch [NS];
  bit pend_chk = 0;
  string pend_req = "";
  logic [7:0] rx [NS][CHMAX];
  logic rxen [NS][CHMAX];
  bit hz_bad [NHZ];

  tdm_tsi #(.NSTR(NS), .CHB(CHB)) i_tdm_tsi (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .st_in(st_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .st_out(st_out), .st_en(st_en), .hz_ctl(hz_ctl));

  always #2.5 clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic sample_bit(int q);
    for (int o = 0; o < NS; o++) begin
      int sh = 3 - int'(ort[o]);
      if ((q & ((1 << sh) - 1)) == 0) begin
        int b = q >> sh;
        rx[o][b >> 3][7 - (b & 7)] = st_out[o];
        if ((b & 7) == 0) rxen[o][b >> 3] = st_en[o];
      end
    end
    for (int o = 0; o < NHZ; o++) if (hz_ctl[o] !== ~st_en[o]) hz_bad[o] = 1;
  endtask

  task automatic evaluate();
    for (int o = 0; o < NS; o++) begin
      for (int c = 0; c < pnch[o]; c++) begin
        string tag;
        logic [8:0] e9, a9;
        if (pend_req == "R1") tag = "R1";
        else if (pmsg[o][c]) tag = "R4";
        else if (!pexen[o][c]) tag = "R5";
        else tag = pend_req;
        e9 = {pexen[o][c], pexen[o][c] ? pex[o][c] : 8'h00};
        a9 = {rxen[o][c], rx[o][c]};
        check(a9 === e9, tag, $sformatf("out%0d ch%0d {en,byte}", o, c), int'(a9), int'(e9));
      end
    end
    for (int o = 0; o < NHZ; o++) check(!hz_bad[o], "R7", $sformatf("hz_ctl%0d vs st_en", o), int'(hz_bad[o]), 0);
  endtask

  task automatic run_frame(bit chk_it, string req);
    logic [7:0] ex [NS][CHMAX];
    logic exen [NS][CHMAX], exm [NS][CHMAX];
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < CHMAX; c++) begin
        logic [9:0] e = cm[o][c];
        exen[o][c] = e[8];
        exm[o][c] = e[9];
        ex[o][c] = e[9] ? e[7:0] : dm[(fr + 1) % 2][e[6:5]][e[4:0]];
      end
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < CHMAX; c++) inb[s][c] = 8'(s * 53 + c * 29 + fr * 17 + 3);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      if (p == 0) begin
        sample_bit(255);
        if (pend_chk) evaluate();
        for (int o = 0; o < NHZ; o++) hz_bad[o] = 0;
      end else sample_bit(p - 1);
      fp_i = (p == 0);
      for (int s = 0; s < NS; s++) begin
        int b = p >> (3 - int'(irt[s]));
        st_in[s] = inb[s][b >> 3][7 - (b & 7)];
      end
      if (p < nq) begin
        wr_en = 1; wr_addr = q_a[p]; wr_data = q_d[p];
      end else wr_en = 0;
    end
    for (int o = 0; o < NS; o++) begin
      pnch[o] = CHB << ort[o];
      for (int c = 0; c < CHMAX; c++) begin
        pex[o][c] = ex[o][c]; pexen[o][c] = exen[o][c]; pmsg[o][c] = exm[o][c];
      end
    end
    if (nq > 0) begin
      for (int s = 0; s < NS; s++) begin
        irt[s] = irt_n[s]; ort[s] = ort_n[s]; bd[s] = bd_n[s];
        for (int c = 0; c < CHMAX; c++) cm[s][c] = cm_n[s][c];
      end
      nq = 0;
    end
    for (int s = 0; s < NS; s++)
      if (!bd[s]) for (int c = 0; c < (CHB << irt[s]); c++) dm[fr % 2][s][c] = inb[s][c];
    pend_chk = chk_it;
    pend_req = req;
    fr++;
  endtask

  function automatic logic [9:0] mk_entry(int o, int c, int mode);
    int ss, sc;
    logic [9:0] e;
    ss = (mode == 2) ? ((c % 2 == 1) ? 1 : o) : (o + c + 1) % NS;
    sc = (c * 3 + o + 1) % (CHB << irt_n[ss]);
    e = {2'b01, 1'b0, 2'(ss), 5'(sc)};
    if (mode == 1 && c % 5 == 2) e = {2'b11, 8'(o * 40 + c * 3 + 1)};
    if (mode == 1 && c % 7 == 4) e[8] = 1'b0;
    return e;
  endfunction

  task automatic build(int mode, logic [7:0] irs, logic [7:0] ors, logic [3:0] bds);
    nq = 0;
    for (int s = 0; s < NS; s++) begin
      irt_n[s] = irs[2*s +: 2]; ort_n[s] = ors[2*s +: 2]; bd_n[s] = bds[s];
      q_a[nq] = 8'(128 + s);
      q_d[nq] = {5'b0, bd_n[s], ort_n[s], irt_n[s]};
      nq++;
    end
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < CHMAX; c++) begin
        cm_n[o][c] = mk_entry(o, c, mode);
        q_a[nq] = 8'(o * CHMAX + c);
        q_d[nq] = cm_n[o][c];
        nq++;
      end
  endtask

  task automatic t_reset();
    for (int s = 0; s < NS; s++) begin
      irt[s] = 0; ort[s] = 0; bd[s] = 0;
      for (int c = 0; c < CHMAX; c++) begin
        cm[s][c] = 10'(s * CHMAX + c);
        dm[0][s][c] = 0; dm[1][s][c] = 0;
      end
    end
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check(st_en == '0, "R1", "st_en in reset", int'(st_en), 0);
    check(hz_ctl == '1, "R1", "hz_ctl in reset", int'(hz_ctl), 3);
    check(st_out == '0, "R1", "st_out in reset", int'(st_out), 0);
    rst_n = 1;
    repeat (37) @(negedge clk);
    run_frame(0, "");
    run_frame(1, "R1");
    run_frame(1, "R1");
  endtask

  task automatic t_switch();
    build(0, 8'h00, 8'h00, 4'h0);
    run_frame(0, ""); run_frame(0, "");
    for (int k = 0; k < 3; k++) run_frame(1, "R2/R8");
  endtask

  task automatic t_rates(logic [7:0] irs, logic [7:0] ors);
    build(1, irs, ors, 4'h0);
    run_frame(0, ""); run_frame(0, "");
    for (int k = 0; k < 3; k++) run_frame(1, "R3");
  endtask

  task automatic t_bidir();
    build(2, 8'b00_10_01_11, 8'b10_00_11_01, 4'b0010);
    run_frame(0, "");
    for (int k = 0; k < 4; k++) run_frame(1, "R6");
  endtask

  initial begin
    t_reset();
    t_switch();
    t_rates(8'b11_10_01_00, 8'b00_01_10_11);
    t_rates(8'b01_00_11_11, 8'b00_10_11_01);
    build(1, 8'b00_10_01_11, 8'b10_00_11_01, 4'h0);
    run_frame(0, ""); run_frame(0, ""); run_frame(1, "R3"); run_frame(1, "R3");
    t_bidir();
    run_frame(0, "");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule